// File: doc/BRIEF.md
# Two-Bit Serial Register Bus Slave

This block is the target side of a narrow configuration bus. A master holds a request strobe high for a whole transfer and shifts in a two-bit slice on every clock cycle. The slice stream holds a direction flag, a 13-bit register address and, on writes, one byte of write data. The length of the request marks the transfer kind: 9 cycles for a read and 11 cycles for a write. The slave decodes the frame, accesses a small internal register file and then answers on a separate acknowledge strobe. The answer is one cycle long for a write. For a read it lasts four cycles and carries the byte back in two-bit slices.

The slave drops any frame that breaks the length rules. It also drops any request that arrives while an earlier transfer is still being answered. Everything runs in the single bus clock domain. Inputs are sampled on the rising edge.

Top module: `srb_slave`

## Requirements
- R1: The first 7 request slices form a 14-bit header, most significant slice first. Header bit 13 is the direction (1 = write) and bits 12:0 are the address. On a write, slices 8 to 11 carry the data byte, most significant pair first. On a read, slices 8 and 9 are ignored.
- R2: A write frame (11 cycles, header bit 13 = 1) raises ack_o for exactly one cycle. Let E be the first rising edge that samples req_i low. ack_o rises on edge E+1.
- R3: A read frame (9 cycles, header bit 13 = 0) raises ack_o for exactly four consecutive cycles, starting on edge E+1. During them dout_o presents the addressed byte, bits 7:6 first and bits 1:0 last.
- R4: dout_o is 2'b00 in every cycle in which ack_o is low.
- R5: These frames cause no register access and no acknowledge: any length other than 9 or 11, a 9-cycle frame with header bit 13 = 1, and an 11-cycle frame with header bit 13 = 0.
- R6: Sixteen 8-bit registers sit at addresses 0 to 15. A read returns the value of the last write to the same address.
- R7: An address with any of bits 12:4 set is out of range. A read of such an address returns 8'h00, and a write to it changes no register, including the register that shares its low four bits.
- R8: A request that is first sampled high after the end of a frame but before that frame's acknowledge has finished is ignored in full, until req_i goes low again.
- R9: While rst_n is low, ack_o and dout_o are 0 and every register is cleared to 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, high for the length of a frame |
| din_i | input | 2 | Serial request slice |
| ack_o | output | 1 | Acknowledge strobe |
| dout_o | output | 2 | Serial read-data slice, valid while ack_o is high |

## Verification
E is the first rising edge that samples req_i low. The receiver registers the decoded frame on E, and the acknowledge stage starts on E+1, so the first acknowledge cycle is visible just after edge E+1. The bench drives on falling edges. It checks that ack_o is still low at the falling edge after E and high at the one after E+1. A write's acknowledge must be gone one falling edge later. For a read, the bench collects slices on four consecutive falling edges and checks that ack_o is low on the fifth. Dropped frames are watched for eight cycles with no acknowledge. A later read through the normal port then shows that no register changed.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int SLICE_W    = 2;
  localparam int ADDR_W     = 13;
  localparam int DATA_W     = 8;
  localparam int HDR_W      = 1 + ADDR_W;
  localparam int HDR_SLICES = HDR_W / SLICE_W;
  localparam int DAT_SLICES = DATA_W / SLICE_W;
  localparam int RD_PAD     = 2;
  localparam int WR_LEN     = HDR_SLICES + DAT_SLICES;
  localparam int RD_LEN     = HDR_SLICES + RD_PAD;
  localparam int SH_W       = WR_LEN * SLICE_W;
  localparam int LEN_W      = $clog2(WR_LEN + 2);

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_DROP  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/srb_rx.sv
module srb_rx
  import srb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [SLICE_W-1:0] din_i,
  input  logic               busy_i,
  output frame_t             frame_o,
  output logic               frame_vld_o
);
  localparam int RD_MSB = SH_W - 1 - (WR_LEN - RD_LEN) * SLICE_W;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  rx_state_e            state_q, state_d;
  logic [LEN_W-1:0]     cnt_q, cnt_d;
  logic [SH_W-1:0]      sh_q, sh_d;
  frame_t               frm_q, frm_d;
  logic                 vld_q, vld_d;
  logic                 is_rd, is_wr;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    frm_d   = frm_q;
    vld_d   = 1'b0;
    is_rd   = (cnt_q == LEN_W'(RD_LEN)) && !sh_q[RD_MSB];
    is_wr   = (cnt_q == LEN_W'(WR_LEN)) && sh_q[SH_W-1];
    case (state_q)
      RX_IDLE: begin
        if (req_i) begin
          if (busy_i) begin
            state_d = RX_DROP;
          end else begin
            state_d = RX_SHIFT;
            cnt_d   = LEN_W'(1);
            sh_d    = {sh_q[SH_W-SLICE_W-1:0], din_i};
          end
        end
      end
      RX_SHIFT: begin
        if (req_i) begin
          cnt_d = (cnt_q == LEN_MAX) ? cnt_q : cnt_q + LEN_W'(1);
          sh_d  = {sh_q[SH_W-SLICE_W-1:0], din_i};
        end else begin
          state_d = RX_IDLE;
          if (is_rd || is_wr) begin
            vld_d      = 1'b1;
            frm_d.wr   = is_wr;
            frm_d.addr = is_wr ? sh_q[SH_W-2 -: ADDR_W] : sh_q[RD_MSB-1 -: ADDR_W];
            frm_d.data = sh_q[DATA_W-1:0];
          end
        end
      end
      RX_DROP: begin
        if (!req_i) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      frm_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      frm_q   <= frm_d;
      vld_q   <= vld_d;
    end
  end

  assign frame_o     = frm_q;
  assign frame_vld_o = vld_q;

  // R2
  vld_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |-> (!$past(req_i) && $past(req_i, 2)));
endmodule

// File: rtl/srb_regfile.sv
module srb_regfile
  import srb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic              in_range;
  logic              wr_en;

  assign idx      = addr_i[IDX_W-1:0];
  assign in_range = (addr_i[ADDR_W-1:IDX_W] == '0);
  assign wr_en    = we_i && in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[idx] <= wdata_i;
    end
  end

  assign rdata_o = in_range ? mem_q[idx] : '0;

  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(idx)] == $past(wdata_i)));
endmodule

// File: rtl/srb_ack.sv
module srb_ack
  import srb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_vld_i,
  input  logic               frame_wr_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic               ack_o,
  output logic [SLICE_W-1:0] dout_o,
  output logic               busy_o
);
  localparam int CNT_W = $clog2(DAT_SLICES + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (frame_vld_i) begin
      cnt_d = frame_wr_i ? CNT_W'(1) : CNT_W'(DAT_SLICES);
      sh_d  = frame_wr_i ? '0 : rdata_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
      sh_d  = {sh_q[DATA_W-SLICE_W-1:0], {SLICE_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign ack_o  = (cnt_q != '0);
  assign dout_o = ack_o ? sh_q[DATA_W-1 -: SLICE_W] : '0;
  assign busy_o = frame_vld_i || ack_o;

  // R2
  wr_ack_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld_i && frame_wr_i) |=> ack_o ##1 !ack_o);

  // R3
  rd_ack_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld_i && !frame_wr_i) |=> ack_o ##1 ack_o ##1 ack_o ##1 ack_o ##1 !ack_o);
endmodule

// File: rtl/srb_slave.sv
module srb_slave
  import srb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [SLICE_W-1:0] din_i,
  output logic               ack_o,
  output logic [SLICE_W-1:0] dout_o
);
  frame_t            frame;
  logic              frame_vld;
  logic              busy;
  logic [DATA_W-1:0] rdata;

  srb_rx u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .din_i       (din_i),
    .busy_i      (busy),
    .frame_o     (frame),
    .frame_vld_o (frame_vld)
  );

  srb_regfile #(.DEPTH(DEPTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (frame_vld && frame.wr),
    .addr_i  (frame.addr),
    .wdata_i (frame.data),
    .rdata_o (rdata)
  );

  srb_ack u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_vld_i (frame_vld),
    .frame_wr_i  (frame.wr),
    .rdata_i     (rdata),
    .ack_o       (ack_o),
    .dout_o      (dout_o),
    .busy_o      (busy)
  );

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> !ack_o);
endmodule

// File: tb/srb_slave_bench.sv
`timescale 1ns/1ps
module srb_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req;
  logic [1:0] din;
  logic       ack;
  logic [1:0] dout;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;
  logic [7:0] model [16];

  always #2 clk = ~clk;

  srb_slave u_srb_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req),
    .din_i  (din),
    .ack_o  (ack),
    .dout_o (dout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_raw(input int len, input logic [21:0] bits);
    for (int i = 0; i < len; i++) begin
      req = 1'b1;
      din = bits[21-2*i -: 2];
      @(negedge clk);
    end
    req = 1'b0;
    din = 2'b00;
  endtask

  task automatic do_write(input logic [12:0] addr, input logic [7:0] data);
    send_raw(11, {1'b1, addr, data});
    @(negedge clk);
    chk("R2 ack low before start", ack, 0);
    chk("R4 dout idle", dout, 0);
    @(negedge clk);
    chk("R2 write ack", ack, 1);
    @(negedge clk);
    chk("R2 write ack one cycle", ack, 0);
    if (addr < 13'd16) model[addr[3:0]] = data;
  endtask

  task automatic do_read(input logic [12:0] addr, input logic [3:0] junk, input int exp,
                         input string tag);
    logic [7:0] got = '0;
    send_raw(9, {1'b0, addr, junk, 4'b0000});
    @(negedge clk);
    chk("R3 ack low before start", ack, 0);
    chk("R4 dout idle", dout, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R3 read ack", ack, 1);
      got = {got[5:0], dout};
    end
    @(negedge clk);
    chk("R3 read ack ends", ack, 0);
    chk("R4 dout after ack", dout, 0);
    chk(tag, got, exp);
  endtask

  task automatic bad_frame(input int len, input logic [21:0] bits);
    bit seen = 1'b0;
    send_raw(len, bits);
    repeat (8) begin
      @(negedge clk);
      if (ack) seen = 1'b1;
    end
    chk("R5 no ack on bad frame", seen, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 ack in reset", ack, 0);
    chk("R9 dout in reset", dout, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    req   = 1'b0;
    din   = 2'b00;
    repeat (3) @(negedge clk);
    do_reset();
    for (int a = 0; a < 16; a++) do_read(13'(a), 4'h0, 0, "R9 register cleared");

    for (int a = 0; a < 16; a++) do_write(13'(a), 8'((a * 37 + 5) & 8'hFF));
    for (int a = 0; a < 16; a++) do_read(13'(a), 4'h0, model[a], "R6 readback");
    for (int a = 0; a < 16; a++) do_write(13'(a), 8'(~((a * 37 + 5) & 8'hFF)));
    for (int a = 15; a >= 0; a--) do_read(13'(a), 4'hF, model[a], "R6 readback second pass");

    // R1: trailing read slices carry no meaning
    for (int j = 0; j < 16; j++) do_read(13'd9, 4'(j), model[9], "R1 read pad ignored");

    // R7: out-of-range addresses
    do_write(13'h0013, 8'hAA);
    do_read(13'h0003, 4'h0, model[3], "R7 alias unchanged");
    do_write(13'h1005, 8'h55);
    do_read(13'h0005, 4'h0, model[5], "R7 alias unchanged high bit");
    do_read(13'h0013, 4'h0, 0, "R7 out-of-range read zero");
    do_read(13'h1FF3, 4'h0, 0, "R7 out-of-range read zero top");

    // R5: illegal lengths and flag mismatches
    for (int len = 1; len <= 14; len++) begin
      if (len != 9 && len != 11) bad_frame(len, {1'b1, 13'd2, 8'h5A});
    end
    bad_frame(9, {1'b1, 13'd2, 8'h5A});
    bad_frame(11, {1'b0, 13'd2, 8'h5A});
    do_read(13'd2, 4'h0, model[2], "R5 register untouched");

    // R8: request while read acknowledge pending
    begin
      logic [21:0] wbits;
      logic [7:0]  got = '0;
      bit          seen = 1'b0;
      wbits = {1'b1, 13'd4, ~model[4]};
      send_raw(9, {1'b0, 13'd4, 8'h00});
      for (int i = 0; i < 11; i++) begin
        @(negedge clk);
        if (i == 0) chk("R8 ack not yet", ack, 0);
        if (i >= 1 && i <= 4) begin
          chk("R8 read ack during intrusion", ack, 1);
          got = {got[5:0], dout};
        end
        if (i == 5) chk("R8 read ack ends", ack, 0);
        req = 1'b1;
        din = wbits[21-2*i -: 2];
      end
      @(negedge clk);
      req = 1'b0;
      din = 2'b00;
      chk("R8 read data intact", got, model[4]);
      repeat (8) begin
        @(negedge clk);
        if (ack) seen = 1'b1;
      end
      chk("R8 ignored request no ack", seen, 0);
      do_read(13'd4, 4'h0, model[4], "R8 ignored write dropped");
    end

    // R9: reset mid-run clears registers
    do_write(13'd7, 8'hC3);
    do_read(13'd7, 4'h0, 8'hC3, "R6 before reset");
    do_reset();
    do_read(13'd7, 4'h0, 0, "R9 cleared after reset");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule